// File: doc/BRIEF.md
# Memory bank strobe decoder

This block sits between the address bus of a 24-bit system and the onboard memory array. It looks at the upper address bits (bits 23 down to 17, one 128K block per code), decides whether the access targets the lower 256K RAM bank, the upper 256K RAM bank or the boot ROM, and produces one select per target. The selects pass through an address-latch-enable controlled hold stage. While the enable is high, the hold stage follows the decode. When the enable is low, it keeps the decision made for the address of the current cycle.

From the held selects the block derives the controls for the bidirectional buffer between the system data bus and the memory data bus. These are the direction, the two byte-lane enables and the parity-check enable. Each RAM bank has its own disable input. With the upper bank disabled, an expansion card can answer 256K to 512K. With both banks disabled, the card can answer all of 0 to 512K, because the buffer never drives the system bus for those addresses.

Top module: `mem_strobe_decoder`

## Requirements
- R1: With `bank_off_i[0]` low, block codes 0x00 and 0x01 on `addr_hi_i` (addresses 0 to 256K-1) assert `ram_sel_o[0]`, and no other select is active.
- R2: With `bank_off_i[1]` low, block codes 0x02 and 0x03 (256K to 512K-1) assert `ram_sel_o[1]`, and no other select is active.
- R3: `bank_off_i[1]` high keeps `ram_sel_o[1]` low for codes 0x02 and 0x03. The buffer then stays disabled for those addresses.
- R4: `bank_off_i[0]` high keeps `ram_sel_o[0]` low for codes 0x00 and 0x01. The buffer then stays disabled for those addresses.
- R5: Block codes 0x07 (0xE0000 to 0xFFFFF) and 0x7F (0xFE0000 to 0xFFFFFF) assert `rom_sel_o`.
- R6: All other block codes assert no select. For those codes `buf_dir_o`, both lane enables and `par_chk_en_o` stay low.
- R7: While `ale_i` is high, the selects follow the address with no clock delay. While `ale_i` is low, address changes are ignored and the selects keep the value captured at the last rising clock edge at which `ale_i` was high.
- R8: `buf_dir_o` is 1 (memory toward system bus) only when `mem_rd_n_i` is low and a RAM or ROM select is active. In every other case it is 0.
- R9: `buf_lo_en_o` is high when a select is active and `addr_lsb_i` is 0. `buf_hi_en_o` is high when a select is active and `bhe_n_i` is 0.
- R10: `par_chk_en_o` is high exactly when a RAM bank select is active. It stays low for ROM accesses.
- R11: While `rst_ni` is low, every output is 0. After reset is released with `ale_i` low, the held selects are all inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; the hold stage captures on its rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_hi_i | input | 7 | Address bits 23..17 (128K block code) |
| addr_lsb_i | input | 1 | Address bit 0 |
| bhe_n_i | input | 1 | Byte-high enable, active low |
| mem_rd_n_i | input | 1 | Memory read command, active low |
| ale_i | input | 1 | Address latch enable; high = transparent |
| bank_off_i | input | 2 | Per-bank disable; bit 0 lower 256K, bit 1 upper 256K |
| ram_sel_o | output | 2 | Held RAM bank strobe selects |
| rom_sel_o | output | 1 | Held ROM select |
| buf_dir_o | output | 1 | Data buffer direction, 1 = toward system bus |
| buf_lo_en_o | output | 1 | Low byte-lane buffer enable |
| buf_hi_en_o | output | 1 | High byte-lane buffer enable |
| par_chk_en_o | output | 1 | Parity check enable |

## Verification
The hardest case to reach from the ports is the hold window. In that window `ale_i` has fallen but the address bus has already moved on, so the outputs must reflect an address that is no longer present at any input. The stimulus opens a cycle with the enable high on a RAM code and lets one clock edge capture it. It then drops the enable and drives unrelated codes, including a ROM code and an unmapped code. The outputs must still show the earlier bank. A final cycle with the enable raised again on an unmapped code confirms that the hold stage releases.

// File: rtl/mem_strobe_pkg.sv
package mem_strobe_pkg;

  typedef enum logic {
    BUF_TO_MEM = 1'b0,
    BUF_TO_SYS = 1'b1
  } buf_dir_e;

  localparam int unsigned BLK_W_DEF     = 7;
  localparam int unsigned NUM_BANKS_DEF = 2;
  localparam int unsigned BANK_BLKS_DEF = 2;

endpackage

// File: rtl/mem_strobe_blk_decode.sv
module mem_strobe_blk_decode #(
  parameter int unsigned    BLK_W     = 7,
  parameter int unsigned    NUM_BANKS = 2,
  parameter int unsigned    BANK_BLKS = 2,
  parameter logic [BLK_W-1:0] ROM_BLK_A = 7'h07,
  parameter logic [BLK_W-1:0] ROM_BLK_B = 7'h7F
) (
  input  logic [BLK_W-1:0]     blk_i,
  input  logic [NUM_BANKS-1:0] bank_off_i,
  output logic [NUM_BANKS-1:0] ram_sel_o,
  output logic                 rom_sel_o
);

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    localparam logic [BLK_W-1:0] BlkFirst = BLK_W'(g * BANK_BLKS);
    localparam logic [BLK_W-1:0] BlkLast  = BLK_W'((g + 1) * BANK_BLKS - 1);
    assign ram_sel_o[g] = !bank_off_i[g] && (blk_i >= BlkFirst) && (blk_i <= BlkLast);
  end

  assign rom_sel_o = (blk_i == ROM_BLK_A) || (blk_i == ROM_BLK_B);

endmodule

// File: rtl/mem_strobe_hold.sv
module mem_strobe_hold #(
  parameter int unsigned W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ale_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hold_q <= '0;
    else if (ale_i) hold_q <= d_i;
  end

  // flow-through while enabled, otherwise last captured decode
  assign q_o = !rst_ni ? '0 : (ale_i ? d_i : hold_q);

endmodule

// File: rtl/mem_strobe_buf_ctl.sv
module mem_strobe_buf_ctl
  import mem_strobe_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 2
) (
  input  logic [NUM_BANKS-1:0] ram_sel_i,
  input  logic                 rom_sel_i,
  input  logic                 mem_rd_n_i,
  input  logic                 addr_lsb_i,
  input  logic                 bhe_n_i,
  output logic                 buf_dir_o,
  output logic                 buf_lo_en_o,
  output logic                 buf_hi_en_o,
  output logic                 par_chk_en_o
);

  logic     any_sel;
  buf_dir_e dir;

  assign any_sel = (|ram_sel_i) | rom_sel_i;

  always_comb begin
    dir = BUF_TO_MEM;
    if (any_sel && !mem_rd_n_i) dir = BUF_TO_SYS;
  end

  assign buf_dir_o    = (dir == BUF_TO_SYS);
  assign buf_lo_en_o  = any_sel & ~addr_lsb_i;
  assign buf_hi_en_o  = any_sel & ~bhe_n_i;
  assign par_chk_en_o = |ram_sel_i;

endmodule

// File: rtl/mem_strobe_decoder.sv
module mem_strobe_decoder
  import mem_strobe_pkg::*;
#(
  parameter int unsigned      BLK_W     = BLK_W_DEF,
  parameter int unsigned      NUM_BANKS = NUM_BANKS_DEF,
  parameter int unsigned      BANK_BLKS = BANK_BLKS_DEF,
  parameter logic [BLK_W-1:0] ROM_BLK_A = 7'h07,
  parameter logic [BLK_W-1:0] ROM_BLK_B = 7'h7F
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [BLK_W-1:0]     addr_hi_i,
  input  logic                 addr_lsb_i,
  input  logic                 bhe_n_i,
  input  logic                 mem_rd_n_i,
  input  logic                 ale_i,
  input  logic [NUM_BANKS-1:0] bank_off_i,
  output logic [NUM_BANKS-1:0] ram_sel_o,
  output logic                 rom_sel_o,
  output logic                 buf_dir_o,
  output logic                 buf_lo_en_o,
  output logic                 buf_hi_en_o,
  output logic                 par_chk_en_o
);

  localparam int unsigned SelW = NUM_BANKS + 1;

  logic [NUM_BANKS-1:0] ram_dec;
  logic                 rom_dec;
  logic [SelW-1:0]      sel_held;

  mem_strobe_blk_decode #(
    .BLK_W    (BLK_W),
    .NUM_BANKS(NUM_BANKS),
    .BANK_BLKS(BANK_BLKS),
    .ROM_BLK_A(ROM_BLK_A),
    .ROM_BLK_B(ROM_BLK_B)
  ) u_dec (
    .blk_i     (addr_hi_i),
    .bank_off_i(bank_off_i),
    .ram_sel_o (ram_dec),
    .rom_sel_o (rom_dec)
  );

  mem_strobe_hold #(.W(SelW)) u_hold (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ale_i (ale_i),
    .d_i   ({rom_dec, ram_dec}),
    .q_o   (sel_held)
  );

  assign ram_sel_o = sel_held[NUM_BANKS-1:0];
  assign rom_sel_o = sel_held[SelW-1];

  mem_strobe_buf_ctl #(.NUM_BANKS(NUM_BANKS)) u_buf (
    .ram_sel_i   (ram_sel_o),
    .rom_sel_i   (rom_sel_o),
    .mem_rd_n_i  (mem_rd_n_i),
    .addr_lsb_i  (addr_lsb_i),
    .bhe_n_i     (bhe_n_i),
    .buf_dir_o   (buf_dir_o),
    .buf_lo_en_o (buf_lo_en_o),
    .buf_hi_en_o (buf_hi_en_o),
    .par_chk_en_o(par_chk_en_o)
  );

endmodule

// File: rtl/mem_strobe_decoder_chk.sv
module mem_strobe_decoder_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ale_i,
  input logic       mem_rd_n_i,
  input logic       addr_lsb_i,
  input logic       bhe_n_i,
  input logic [1:0] bank_off_i,
  input logic [1:0] ram_sel_o,
  input logic       rom_sel_o,
  input logic       buf_dir_o,
  input logic       buf_lo_en_o,
  input logic       buf_hi_en_o,
  input logic       par_chk_en_o
);

  // R3
  hi_bank_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ale_i && bank_off_i[1]) |-> !ram_sel_o[1]);

  // R4
  lo_bank_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ale_i && bank_off_i[0]) |-> !ram_sel_o[0]);

  // R6
  single_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ram_sel_o, rom_sel_o}));

  // R7
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ale_i && !$past(ale_i)) |-> ($stable(ram_sel_o) && $stable(rom_sel_o)));

  // R8
  dir_read_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_dir_o |-> (!mem_rd_n_i && (ram_sel_o != 2'b00 || rom_sel_o)));

  // R9
  lane_cond_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((buf_lo_en_o |-> !addr_lsb_i) and (buf_hi_en_o |-> !bhe_n_i)));

  // R10
  parity_ram_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_chk_en_o |-> (ram_sel_o != 2'b00 && !rom_sel_o));

endmodule

bind mem_strobe_decoder mem_strobe_decoder_chk chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ale_i       (ale_i),
  .mem_rd_n_i  (mem_rd_n_i),
  .addr_lsb_i  (addr_lsb_i),
  .bhe_n_i     (bhe_n_i),
  .bank_off_i  (bank_off_i),
  .ram_sel_o   (ram_sel_o),
  .rom_sel_o   (rom_sel_o),
  .buf_dir_o   (buf_dir_o),
  .buf_lo_en_o (buf_lo_en_o),
  .buf_hi_en_o (buf_hi_en_o),
  .par_chk_en_o(par_chk_en_o)
);

// File: tb/mem_strobe_decoder_tb_top.sv
module mem_strobe_decoder_tb_top;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [6:0] addr_hi_i = '0;
  logic       addr_lsb_i = 1'b0;
  logic       bhe_n_i = 1'b1;
  logic       mem_rd_n_i = 1'b1;
  logic       ale_i = 1'b0;
  logic [1:0] bank_off_i = '0;
  logic [1:0] ram_sel_o;
  logic       rom_sel_o, buf_dir_o, buf_lo_en_o, buf_hi_en_o, par_chk_en_o;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  mem_strobe_decoder dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_hi_i(addr_hi_i), .addr_lsb_i(addr_lsb_i),
    .bhe_n_i(bhe_n_i), .mem_rd_n_i(mem_rd_n_i), .ale_i(ale_i), .bank_off_i(bank_off_i),
    .ram_sel_o(ram_sel_o), .rom_sel_o(rom_sel_o), .buf_dir_o(buf_dir_o),
    .buf_lo_en_o(buf_lo_en_o), .buf_hi_en_o(buf_hi_en_o), .par_chk_en_o(par_chk_en_o)
  );

  typedef struct {
    logic [6:0] exp;
    string      tag;
  } item_t;

  item_t sb_q[$];
  event  sample_ev;

  // bench view of the captured selects: {rom, ram[1:0]}
  logic [2:0] cap_sel = 3'b000;

  function automatic logic [2:0] model_sel(input logic [6:0] blk, input logic [1:0] off);
    logic [2:0] s;
    s[0] = !off[0] && (blk == 7'h00 || blk == 7'h01);
    s[1] = !off[1] && (blk == 7'h02 || blk == 7'h03);
    s[2] = (blk == 7'h07 || blk == 7'h7F);
    return s;
  endfunction

  function automatic logic [6:0] model_out(input logic [2:0] s, input logic rd_n,
                                           input logic a0, input logic bhe_n);
    logic any;
    any = |s;
    // {ram[1:0], rom, dir, lo, hi, par}
    return {s[1], s[0], s[2], any & ~rd_n, any & ~a0, any & ~bhe_n, s[0] | s[1]};
  endfunction

  task automatic drive(input logic [6:0] blk, input logic [1:0] off, input logic ale,
                       input logic rd_n, input logic a0, input logic bhe_n, input string tag);
    item_t it;
    logic [2:0] eff;
    @(negedge clk_i);
    addr_hi_i  = blk;
    bank_off_i = off;
    ale_i      = ale;
    mem_rd_n_i = rd_n;
    addr_lsb_i = a0;
    bhe_n_i    = bhe_n;
    eff = ale ? model_sel(blk, off) : cap_sel;
    if (ale) cap_sel = eff;
    it.exp = model_out(eff, rd_n, a0, bhe_n);
    it.tag = tag;
    sb_q.push_back(it);
    #2;
    ->sample_ev;
  endtask

  initial begin : monitor
    forever begin
      item_t it;
      logic [6:0] act;
      @(sample_ev);
      it  = sb_q.pop_front();
      act = {ram_sel_o, rom_sel_o, buf_dir_o, buf_lo_en_o, buf_hi_en_o, par_chk_en_o};
      n_checks++;
      if (act !== it.exp) begin
        n_errors++;
        $display("FAIL %s: got %b expected %b", it.tag, act, it.exp);
      end
    end
  end

  initial begin : watchdog
    #2000000;
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin : stim
    // R11: outputs quiet in reset even with a decodable address
    ale_i = 1'b1; addr_hi_i = 7'h00; mem_rd_n_i = 1'b0; bhe_n_i = 1'b0;
    #13;
    n_checks++;
    if ({ram_sel_o, rom_sel_o, buf_dir_o, buf_lo_en_o, buf_hi_en_o, par_chk_en_o} !== 7'b0) begin
      n_errors++;
      $display("FAIL R11: got %b expected 0000000",
               {ram_sel_o, rom_sel_o, buf_dir_o, buf_lo_en_o, buf_hi_en_o, par_chk_en_o});
    end
    ale_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    cap_sel = 3'b000;
    drive(7'h00, 2'b00, 0, 0, 0, 0, "R11 held after reset");

    drive(7'h00, 2'b00, 1, 0, 0, 0, "R1 block0 read");
    drive(7'h01, 2'b00, 1, 0, 0, 0, "R1 block1 read");
    drive(7'h02, 2'b00, 1, 1, 0, 0, "R2 block2 write");
    drive(7'h03, 2'b00, 1, 1, 0, 0, "R2 block3 write");
    drive(7'h02, 2'b10, 1, 0, 0, 0, "R3 upper off");
    drive(7'h03, 2'b10, 1, 0, 0, 0, "R3 upper off top");
    drive(7'h01, 2'b10, 1, 0, 0, 0, "R3 lower kept");
    drive(7'h00, 2'b01, 1, 0, 0, 0, "R4 lower off");
    drive(7'h01, 2'b11, 1, 0, 0, 0, "R4 both off");
    drive(7'h02, 2'b01, 1, 0, 0, 0, "R4 upper kept");
    drive(7'h07, 2'b00, 1, 0, 0, 0, "R5 rom low alias R10");
    drive(7'h7F, 2'b00, 1, 0, 0, 0, "R5 rom top");
    drive(7'h04, 2'b00, 1, 0, 0, 0, "R6 block4");
    drive(7'h06, 2'b00, 1, 0, 0, 0, "R6 block6");
    drive(7'h08, 2'b00, 1, 0, 0, 0, "R6 block8");
    drive(7'h7E, 2'b00, 1, 0, 0, 0, "R6 block7E");
    drive(7'h01, 2'b00, 1, 1, 1, 1, "R8 no read R9 no lanes");
    drive(7'h01, 2'b00, 1, 0, 1, 0, "R9 odd byte");
    drive(7'h03, 2'b00, 1, 0, 0, 1, "R9 even byte");
    drive(7'h02, 2'b00, 1, 0, 0, 0, "R7 capture");
    drive(7'h05, 2'b00, 0, 0, 0, 0, "R7 hold vs unmapped");
    drive(7'h7F, 2'b00, 0, 0, 0, 0, "R7 hold vs rom");
    drive(7'h00, 2'b10, 0, 1, 0, 0, "R7 hold vs off");
    drive(7'h05, 2'b00, 1, 0, 0, 0, "R7 release");
    drive(7'h00, 2'b00, 0, 0, 0, 0, "R7 hold empty");

    @(negedge clk_i);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule